// File: doc/BRIEF.md
# Register-List Block Transfer Sequencer

This block sequences a multi-register load or store. It takes a mask of the architectural registers to move, a word-aligned base address and a direction. It then drives a 64-bit memory port one beat per cycle, with two 32-bit lanes per beat. Registers are taken lowest-numbered first and go to ascending word addresses from the base. When the current word address sits on a doubleword boundary, a beat carries two registers. When it does not, the beat carries a single word in the upper lane, and the following beats are pairs again. The number of busy cycles therefore depends only on the register count and on address bit 2 of the base.

The main ALU pipeline is held only in the first cycle of the transfer. After that the transfer runs on its own. The block keeps a mask of registers that are not yet transferred. A younger instruction places the register number it depends on at the query input, and the block raises a stall only while that register is still pending. A dependency on an early register therefore clears sooner than one on a late register. An empty list occupies one cycle and makes no memory access.

Top module: `lsm_sequencer`

## Requirements
- R1: After reset, busy, stall, done, alu_hold and mem_en are low, mem_lanes is 0 and pending is all zero.
- R2: Registers are moved in ascending register number, to ascending word addresses that start at the base. mem_addr is a doubleword-aligned byte address. Lane bit 0 carries lo_reg at mem_addr and lane bit 1 carries hi_reg at mem_addr+4.
- R3: With base bit 2 clear, every beat carries two registers except a final odd one, which uses lane 0 only. A list of N registers takes ceil(N/2) beats, so lists of 2k and 2k-1 registers take the same time.
- R4: With base bit 2 set, the first beat carries only the lowest register, in lane 1 (mem_lanes = 2'b10). Pairs follow, for floor(N/2)+1 beats in total: one more than aligned for an even count.
- R5: mem_we is high on every beat of a store (is_load = 0) and low on every beat of a load.
- R6: alu_hold is high in the first busy cycle of a transfer and in no other cycle.
- R7: pending equals the accepted list in the first busy cycle. Each register's bit drops at the end of the beat that moves it.
- R8: stall equals the pending bit selected by query_reg.
- R9: An empty list gives exactly one busy cycle, with done high and mem_en low.
- R10: A start request while busy is ignored: the running sequence, pending and beat count are unchanged.
- R11: done is high only in the last busy cycle of a transfer, and busy is low in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a transfer; accepted when not busy |
| reg_list | input | NREGS | Mask of registers to move |
| base | input | AW | Word-aligned start byte address |
| is_load | input | 1 | 1 = load, 0 = store |
| query_reg | input | RIW | Register a younger instruction depends on |
| busy | output | 1 | Transfer in progress |
| alu_hold | output | 1 | ALU pipeline occupied (first cycle only) |
| done | output | 1 | Last cycle of the transfer |
| mem_en | output | 1 | Memory beat valid |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | AW | Doubleword-aligned beat address |
| mem_lanes | output | 2 | Active 32-bit lanes (bit 0 low, bit 1 high) |
| lo_reg | output | RIW | Register in lane 0 |
| hi_reg | output | RIW | Register in lane 1 |
| pending | output | NREGS | Registers not yet moved |
| stall | output | 1 | Queried register still pending |

## Verification
The assertions assume a word-aligned base, because bits 1:0 are discarded. They also assume that start is raised only while the block is idle, or that a start raised while busy has no effect. The monotone-address and lane-shape properties hold only if the base does not wrap the top of the address space. The stimulus keeps every base word-aligned and far below the wrap point. It raises start while busy in exactly one run, to show that the request is ignored.

// File: rtl/lsm_sequencer.sv
module lsm_sequencer #(
  parameter int NREGS = 16,
  parameter int AW    = 32,
  localparam int RIW  = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NREGS-1:0] reg_list,
  input  logic [AW-1:0]    base,
  input  logic             is_load,
  input  logic [RIW-1:0]   query_reg,
  output logic             busy,
  output logic             alu_hold,
  output logic             done,
  output logic             mem_en,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [1:0]       mem_lanes,
  output logic [RIW-1:0]   lo_reg,
  output logic [RIW-1:0]   hi_reg,
  output logic [NREGS-1:0] pending,
  output logic             stall
);

  logic [NREGS-1:0] rem, rem_nxt, take;
  logic [AW-1:0]    wptr;
  logic             first, store;
  logic [RIW-1:0]   r0, r1;
  logic             v0, v1;

  always_comb begin
    r0 = '0; r1 = '0; v0 = 1'b0; v1 = 1'b0;
    for (int i = 0; i < NREGS; i++) begin
      if (rem[i] && !v0) begin
        v0 = 1'b1; r0 = RIW'(i);
      end else if (rem[i] && v0 && !v1) begin
        v1 = 1'b1; r1 = RIW'(i);
      end
    end
  end

  wire odd_word = wptr[2];
  wire pair     = v1 && !odd_word;

  assign take    = (v0 ? (NREGS'(1) << r0) : '0) | (pair ? (NREGS'(1) << r1) : '0);
  assign rem_nxt = rem & ~take;

  assign mem_en    = busy && v0;
  assign mem_we    = mem_en && store;
  assign mem_addr  = {wptr[AW-1:3], 3'b000};
  assign mem_lanes = !mem_en ? 2'b00 : odd_word ? 2'b10 : pair ? 2'b11 : 2'b01;
  assign lo_reg    = r0;
  assign hi_reg    = odd_word ? r0 : r1;
  assign done      = busy && (rem_nxt == '0);
  assign alu_hold  = busy && first;
  assign pending   = rem;
  assign stall     = rem[query_reg];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      rem   <= '0;
      wptr  <= '0;
      first <= 1'b0;
      store <= 1'b0;
    end else if (!busy) begin
      if (start) begin
        busy  <= 1'b1;
        rem   <= reg_list;
        wptr  <= {base[AW-1:2], 2'b00};
        first <= 1'b1;
        store <= !is_load;
      end
    end else begin
      rem   <= rem_nxt;
      wptr  <= wptr + (pair ? AW'(8) : AW'(4));
      first <= 1'b0;
      if (done) busy <= 1'b0;
    end
  end

  p_lanes_need_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en == (mem_lanes != 2'b00)));

  p_dw_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> (mem_addr[2:0] == 3'b000));

  p_addr_ascends_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !done) |=> (mem_addr == $past(mem_addr) || mem_addr == $past(mem_addr) + AW'(8)));

  p_lo_only_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_lanes == 2'b01) |-> done);

  p_hi_only_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_lanes == 2'b10) |-> alu_hold);

  p_hold_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    alu_hold |=> !alu_hold);

  p_pending_shrinks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ((pending & ~$past(pending)) == '0));

  p_stall_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> busy);

  p_done_ends_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

endmodule

// File: tb/sim_lsm_sequencer.sv
module sim_lsm_sequencer;
  localparam int NREGS = 16;
  localparam int AW    = 32;
  localparam int RIW   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [NREGS-1:0] reg_list = '0;
  logic [AW-1:0] base = '0;
  logic is_load = 1'b0;
  logic [RIW-1:0] query_reg = '0;
  logic busy, alu_hold, done, mem_en, mem_we, stall;
  logic [AW-1:0] mem_addr;
  logic [1:0] mem_lanes;
  logic [RIW-1:0] lo_reg, hi_reg;
  logic [NREGS-1:0] pending;

  always #2 clk = ~clk;

  lsm_sequencer #(.NREGS(NREGS), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .reg_list(reg_list), .base(base),
    .is_load(is_load), .query_reg(query_reg), .busy(busy), .alu_hold(alu_hold),
    .done(done), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_lanes(mem_lanes), .lo_reg(lo_reg), .hi_reg(hi_reg), .pending(pending),
    .stall(stall));

  int checks = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // {list, base, is_load, beats}
  localparam logic [56:0] VEC [9] = '{
    {16'h000F, 32'h0000_1000, 1'b0, 8'd2},
    {16'h0007, 32'h0000_1000, 1'b1, 8'd2},
    {16'h000F, 32'h0000_1004, 1'b1, 8'd3},
    {16'h0007, 32'h0000_1004, 1'b0, 8'd2},
    {16'h8001, 32'h0000_2000, 1'b1, 8'd1},
    {16'h0001, 32'h0000_2004, 1'b0, 8'd1},
    {16'hFFFF, 32'h0000_3008, 1'b1, 8'd8},
    {16'hA5A5, 32'h0000_300C, 1'b0, 8'd5},
    {16'h4002, 32'h0000_5004, 1'b1, 8'd2}
  };

  task automatic run_vec(input logic [15:0] lst, input logic [31:0] b, input bit ld,
                         input int exp_beats, input logic [3:0] q, input bit poke);
    int regs[16];
    int n = 0;
    int idx = 0;
    int beats = 0;
    logic [31:0] wa;
    logic [15:0] pend;
    for (int i = 0; i < 16; i++) if (lst[i]) begin regs[n] = i; n++; end
    wa = {b[31:2], 2'b00};
    pend = lst;
    @(negedge clk);
    reg_list = lst; base = b; is_load = ld; query_reg = q; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (idx < n && beats < 40) begin
      logic [1:0] el;
      logic [31:0] ea;
      int elo = 0;
      int ehi = 0;
      ea = {wa[31:3], 3'b000};
      if (wa[2]) begin el = 2'b10; ehi = regs[idx]; idx++; wa += 4; end
      else begin
        elo = regs[idx]; idx++;
        if (idx < n) begin el = 2'b11; ehi = regs[idx]; idx++; wa += 8; end
        else begin el = 2'b01; wa += 4; end
      end
      chk(mem_en === 1'b1, "R2", "mem_en", mem_en, 1);
      chk(mem_addr === ea, "R2", "mem_addr", mem_addr, ea);
      chk(mem_lanes === el, b[2] ? "R4" : "R3", "mem_lanes", mem_lanes, el);
      if (el[0]) chk(lo_reg == elo, "R2", "lo_reg", lo_reg, elo);
      if (el[1]) chk(hi_reg == ehi, "R2", "hi_reg", hi_reg, ehi);
      chk(mem_we === !ld, "R5", "mem_we", mem_we, !ld);
      chk(alu_hold === (beats == 0), "R6", "alu_hold", alu_hold, beats == 0);
      chk(pending === pend, "R7", "pending", pending, pend);
      chk(stall === pend[q], "R8", "stall", stall, pend[q]);
      chk(done === (idx == n), "R11", "done", done, idx == n);
      if (el[0]) pend[elo] = 1'b0;
      if (el[1]) pend[ehi] = 1'b0;
      beats++;
      if (poke && beats == 1) begin
        reg_list = 16'hFFFF; base = 32'h0000_0004; is_load = !ld; start = 1'b1; // R10
      end else start = 1'b0;
      @(negedge clk);
      start = 1'b0;
    end
    chk(beats == exp_beats, b[2] ? "R4" : "R3", "beat count", beats, exp_beats);
    chk(busy === 1'b0, poke ? "R10" : "R11", "busy after done", busy, 0);
    chk(stall === 1'b0, "R8", "stall after done", stall, 0);
  endtask

  initial begin
    #800000;
    fails++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && mem_en === 1'b0 && done === 1'b0 && alu_hold === 1'b0,
        "R1", "control idle", {busy, mem_en, done, alu_hold}, 0);
    chk(pending === '0 && stall === 1'b0 && mem_lanes === 2'b00, "R1", "pending/stall/lanes",
        {pending, stall, mem_lanes}, 0);
    rst_n = 1'b1;

    for (int k = 0; k < 9; k++) begin
      logic [15:0] l;
      logic [3:0] q;
      l = VEC[k][56:41];
      q = 4'd0;
      for (int i = 0; i < 16; i++) if (l[i]) begin q = 4'(i); break; end
      run_vec(l, VEC[k][40:9], VEC[k][8], int'(VEC[k][7:0]), q, 1'b0);
    end

    // R8: late register stalls through the final beat
    run_vec(16'h00FF, 32'h0000_6000, 1'b0, 4, 4'd7, 1'b0);
    // R10: start while busy ignored
    run_vec(16'h0F0F, 32'h0000_7000, 1'b1, 4, 4'd9, 1'b1);
    // R3 vs R4: even list, aligned 3 beats, unaligned 4 beats
    run_vec(16'h003F, 32'h0000_8000, 1'b1, 3, 4'd3, 1'b0);
    run_vec(16'h003F, 32'h0000_8004, 1'b1, 4, 4'd3, 1'b0);

    // R9: empty list
    @(negedge clk);
    reg_list = '0; base = 32'h0000_9000; is_load = 1'b1; query_reg = 4'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1 && done === 1'b1, "R9", "empty busy/done", {busy, done}, 2'b11);
    chk(mem_en === 1'b0 && mem_lanes === 2'b00, "R9", "empty no access", {mem_en, mem_lanes}, 0);
    chk(alu_hold === 1'b1, "R6", "empty alu_hold", alu_hold, 1);
    @(negedge clk);
    chk(busy === 1'b0, "R9", "empty one cycle", busy, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule